// File: doc/BRIEF.md
# Anti-Diagonal State Sequencer for a 2-D State-Space Recursion

This block drives the recursion of a two-dimensional state-space system over a finite grid of ROWS by COLS points, visiting the points one anti-diagonal at a time. It keeps the horizontal state vectors in one bank of slots, with one slot per column index m. It keeps the vertical state vectors in a second bank, with one slot per row index n. At each step it presents the current grid point (n, m) to an external matrix-vector unit, together with the horizontal slot m and the vertical slot n as operands. It then waits for that unit to return the two updated vectors, and writes each one back into the slot it was read from.

The delay between producing a state and consuming it changes along the sweep, so the storage cannot be a fixed shift cascade. Slot selection follows the visit order instead. That order comes either from a table of grid points computed at elaboration or from an incremental walker, and a parameter picks between the two.

Boundary states are written into the slots through a load port while no sweep is running. A start pulse then begins a frame. After the last grid point is accepted, a done flag rises and stays high until the next start.

Top module: `diag_state_sched`

## Requirements
- R1: After reset, op_valid and done are both 0 and every slot holds zero.
- R2: While op_valid is 1, (op_n, op_m) follows anti-diagonals d = n+m in increasing d. Within one diagonal, n increases. With the defaults (3 rows, 4 columns) the order is (0,0) (0,1) (1,0) (0,2) (1,1) (2,0) (0,3) (1,2) (2,1) (1,3) (2,2) (2,3).
- R3: While op_valid is 1, op_xh equals the content of horizontal slot op_m and op_xv equals the content of vertical slot op_n.
- R4: A cycle with op_valid and res_valid both 1 writes res_xh into horizontal slot op_m and res_xv into vertical slot op_n, and advances to the next point. While res_valid is 0, every op_* output holds. A slot read and written in the same step shows its old value until the clock edge.
- R5: The cycle after the last point is accepted, op_valid is 0 and done is 1. done stays 1 until a start is accepted.
- R6: A load with ld_en=1 writes ld_data into horizontal slot ld_addr when ld_sel=0. When ld_sel=1 it writes the low V_LEN*DW bits of ld_data into vertical slot ld_addr. A load made while op_valid is 1 has no effect.
- R7: A start pulse while op_valid is 0 begins a frame at point (0,0) on the next cycle and clears done. A start pulse while op_valid is 1 has no effect.
- R8: A load presented in the same cycle as an accepted start is written before step 0 reads its operands.
- R9: A slot that is not reloaded between frames keeps the last value written to it in the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame sweep |
| ld_en | input | 1 | Boundary load strobe |
| ld_sel | input | 1 | 0 selects the horizontal bank, 1 the vertical bank |
| ld_addr | input | max(clog2(ROWS),clog2(COLS)) | Slot index for the load |
| ld_data | input | max(H_LEN,V_LEN)*DW | Boundary state vector |
| op_valid | output | 1 | Operands for the current point are presented |
| op_n | output | clog2(ROWS) | Current row index |
| op_m | output | clog2(COLS) | Current column index |
| op_xh | output | H_LEN*DW | Horizontal state operand |
| op_xv | output | V_LEN*DW | Vertical state operand |
| res_valid | input | 1 | Updated states are presented by the arithmetic unit |
| res_xh | input | H_LEN*DW | Updated horizontal state |
| res_xv | input | V_LEN*DW | Updated vertical state |
| done | output | 1 | Frame sweep finished |

## Verification
Two pairs of functions can fall in the same cycle. In the first, an accepted start coincides with a boundary load. The bench issues the final boundary load together with the start pulse and expects the step-0 operand to show the freshly loaded value. In the second, a slot is written and read in the same step. It is also possible for a load or start to arrive while a step is pending. For the write-and-read case, the bench's reference model requires the old slot value on the operand outputs until res_valid is taken. For loads and starts during a pending step, the bench injects them in the middle of a frame and judges them by the operand that the affected slot delivers several steps later.

// File: rtl/dss_pkg.sv
package dss_pkg;

   typedef struct packed {
      int n;
      int m;
   } pos_t;

   // Successor of a grid point in the anti-diagonal sweep.
   function automatic pos_t next_pos(input int rows, input int cols, input pos_t p);
      pos_t r;
      int   d;
      if ((p.n + 1 < rows) && (p.m > 0)) begin
         r.n = p.n + 1;
         r.m = p.m - 1;
      end else begin
         d   = p.n + p.m + 1;
         r.n = (d > cols - 1) ? d - (cols - 1) : 0;
         r.m = d - r.n;
      end
      return r;
   endfunction

   // Grid point visited at step t.
   function automatic pos_t nth_pos(input int rows, input int cols, input int t);
      pos_t p;
      p = '0;
      for (int k = 0; k < t; k++) p = next_pos(rows, cols, p);
      return p;
   endfunction

endpackage

// File: rtl/dss_slot_bank.sv
module dss_slot_bank #(
   parameter int SLOTS = 4,
   parameter int W     = 48,
   parameter int AW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam logic [AW:0] LIM = (AW+1)'(SLOTS);

   logic [W-1:0] mem [SLOTS];

   if ((1 << AW) < SLOTS) begin : g_bad_aw
      $error("slot bank address too narrow");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
      end else if (we && ({1'b0, waddr} < LIM)) begin
         mem[waddr] <= wdata;
      end
   end

   // Read is combinational from the registers: a same-step write shows next cycle.
   assign rdata = ({1'b0, raddr} < LIM) ? mem[raddr] : '0;

endmodule

// File: rtl/dss_walker.sv
module dss_walker #(
   parameter int ROWS      = 3,
   parameter int COLS      = 4,
   parameter int ORDER_ROM = 1,
   parameter int NW        = 2,
   parameter int MW        = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          adv,
   output logic [NW-1:0] pos_n,
   output logic [MW-1:0] pos_m,
   output logic          last
);
   localparam int STEPS = ROWS * COLS;
   localparam int TW    = $clog2(STEPS);

   if (ORDER_ROM != 0) begin : g_rom
      logic [NW-1:0] rom_n [STEPS];
      logic [MW-1:0] rom_m [STEPS];
      logic [TW-1:0] t_q;

      for (genvar i = 0; i < STEPS; i++) begin : g_ent
         localparam dss_pkg::pos_t P = dss_pkg::nth_pos(ROWS, COLS, i);
         assign rom_n[i] = NW'(P.n);
         assign rom_m[i] = MW'(P.m);
      end

      always_ff @(posedge clk) begin
         if (!rst_n)             t_q <= '0;
         else if (init)          t_q <= '0;
         else if (adv && !last)  t_q <= t_q + 1'b1;
      end

      assign pos_n = rom_n[t_q];
      assign pos_m = rom_m[t_q];
      assign last  = (t_q == TW'(STEPS - 1));
   end else begin : g_walk
      logic [NW-1:0] n_q;
      logic [MW-1:0] m_q;
      dss_pkg::pos_t cur, nxt;

      always_comb begin
         cur.n = int'(n_q);
         cur.m = int'(m_q);
         nxt   = dss_pkg::next_pos(ROWS, COLS, cur);
      end

      always_ff @(posedge clk) begin
         if (!rst_n || init) begin
            n_q <= '0;
            m_q <= '0;
         end else if (adv && !last) begin
            n_q <= NW'(nxt.n);
            m_q <= MW'(nxt.m);
         end
      end

      assign pos_n = n_q;
      assign pos_m = m_q;
      assign last  = (n_q == NW'(ROWS - 1)) && (m_q == MW'(COLS - 1));
   end

endmodule

// File: rtl/diag_state_sched.sv
module diag_state_sched #(
   parameter int DW        = 16,
   parameter int H_LEN     = 3,
   parameter int V_LEN     = 2,
   parameter int ROWS      = 3,
   parameter int COLS      = 4,
   parameter int ORDER_ROM = 1,
   localparam int HW  = H_LEN * DW,
   localparam int VW  = V_LEN * DW,
   localparam int LDW = (HW > VW) ? HW : VW,
   localparam int NW  = $clog2(ROWS),
   localparam int MW  = $clog2(COLS),
   localparam int LAW = (NW > MW) ? NW : MW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           ld_en,
   input  logic           ld_sel,
   input  logic [LAW-1:0] ld_addr,
   input  logic [LDW-1:0] ld_data,
   output logic           op_valid,
   output logic [NW-1:0]  op_n,
   output logic [MW-1:0]  op_m,
   output logic [HW-1:0]  op_xh,
   output logic [VW-1:0]  op_xv,
   input  logic           res_valid,
   input  logic [HW-1:0]  res_xh,
   input  logic [VW-1:0]  res_xv,
   output logic           done
);
   if (ROWS < 2 || COLS < 2) begin : g_bad_grid
      $error("grid needs at least two rows and two columns");
   end
   if (DW < 1 || H_LEN < 1 || V_LEN < 1) begin : g_bad_vec
      $error("state vectors must be non-empty");
   end

   logic          run_q, done_q, last_step;
   logic          start_ok, adv;
   logic          h_ld, v_ld, h_we, v_we;
   logic [MW-1:0] h_waddr;
   logic [NW-1:0] v_waddr;
   logic [HW-1:0] h_wdata;
   logic [VW-1:0] v_wdata;

   assign start_ok = start && !run_q;
   assign adv      = run_q && res_valid;

   // Loads only while idle; out-of-range slot numbers are dropped.
   assign h_ld = ld_en && !run_q && !ld_sel && ({1'b0, ld_addr} < (LAW+1)'(COLS));
   assign v_ld = ld_en && !run_q &&  ld_sel && ({1'b0, ld_addr} < (LAW+1)'(ROWS));

   assign h_we    = adv || h_ld;
   assign v_we    = adv || v_ld;
   assign h_waddr = adv ? op_m : ld_addr[MW-1:0];
   assign v_waddr = adv ? op_n : ld_addr[NW-1:0];
   assign h_wdata = adv ? res_xh : ld_data[HW-1:0];
   assign v_wdata = adv ? res_xv : ld_data[VW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (start_ok) begin
         run_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (adv && last_step) begin
         run_q  <= 1'b0;
         done_q <= 1'b1;
      end
   end

   dss_walker #(
      .ROWS(ROWS), .COLS(COLS), .ORDER_ROM(ORDER_ROM), .NW(NW), .MW(MW)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .init(start_ok), .adv(adv),
      .pos_n(op_n), .pos_m(op_m), .last(last_step)
   );

   dss_slot_bank #(.SLOTS(COLS), .W(HW), .AW(MW)) u_hbank (
      .clk(clk), .rst_n(rst_n), .we(h_we), .waddr(h_waddr), .wdata(h_wdata),
      .raddr(op_m), .rdata(op_xh)
   );

   dss_slot_bank #(.SLOTS(ROWS), .W(VW), .AW(NW)) u_vbank (
      .clk(clk), .rst_n(rst_n), .we(v_we), .waddr(v_waddr), .wdata(v_wdata),
      .raddr(op_n), .rdata(op_xv)
   );

   assign op_valid = run_q;
   assign done     = done_q;

   // Sweep successor: same diagonal one row down, or first point of the next diagonal.
   assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && res_valid && !last_step |=> op_valid &&
      (((int'(op_n) == int'($past(op_n)) + 1) && (int'(op_m) == int'($past(op_m)) - 1)) ||
       (int'(op_n) + int'(op_m) == int'($past(op_n)) + int'($past(op_m)) + 1)));

   assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !res_valid |=> op_valid && $stable(op_n) && $stable(op_m) &&
      $stable(op_xh) && $stable(op_xv));

   assert_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && res_valid && last_step |=> done && !op_valid);

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !op_valid);

   assert_load_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && ld_en && !res_valid |=> $stable(op_xh) && $stable(op_xv));

   assert_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_valid) |-> (op_n == '0) && (op_m == '0));

endmodule

// File: tb/sim_diag_state_sched.sv
`timescale 1ns/1ps
module sim_diag_state_sched;
   localparam int DW = 16, H_LEN = 3, V_LEN = 2, ROWS = 3, COLS = 4;
   localparam int HW = H_LEN * DW, VW = V_LEN * DW, LDW = (HW > VW) ? HW : VW;
   localparam int STEPS = ROWS * COLS;

   logic           clk = 1'b0, rst_n = 1'b0;
   logic           start = 1'b0, ld_en = 1'b0, ld_sel = 1'b0, res_valid = 1'b0;
   logic [1:0]     ld_addr = '0;
   logic [LDW-1:0] ld_data = '0;
   logic [HW-1:0]  res_xh = '0;
   logic [VW-1:0]  res_xv = '0;
   logic           op_valid, done;
   logic [1:0]     op_n, op_m;
   logic [HW-1:0]  op_xh;
   logic [VW-1:0]  op_xv;

   always #2 clk = ~clk;

   diag_state_sched #(.DW(DW), .H_LEN(H_LEN), .V_LEN(V_LEN), .ROWS(ROWS), .COLS(COLS)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_addr(ld_addr), .ld_data(ld_data), .op_valid(op_valid), .op_n(op_n),
      .op_m(op_m), .op_xh(op_xh), .op_xv(op_xv), .res_valid(res_valid),
      .res_xh(res_xh), .res_xv(res_xv), .done(done)
   );

   int n_chk = 0, n_fail = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Reference model: expected visit list and slot contents.
   int          exp_n [STEPS];
   int          exp_m [STEPS];
   logic [HW-1:0] mh [COLS];
   logic [VW-1:0] mv [ROWS];
   int          mt;
   bit          mrun, mdone;

   initial begin
      int k = 0;
      for (int d = 0; d <= ROWS + COLS - 2; d++)
         for (int n = 0; n < ROWS; n++)
            if (d - n >= 0 && d - n < COLS) begin
               exp_n[k] = n;
               exp_m[k] = d - n;
               k++;
            end
   end

   always @(posedge clk) begin
      bit was_run;
      if (!rst_n) begin
         for (int i = 0; i < COLS; i++) mh[i] = '0;
         for (int i = 0; i < ROWS; i++) mv[i] = '0;
         mt = 0; mrun = 0; mdone = 0;
      end else begin
         was_run = mrun;
         if (ld_en && !was_run) begin
            if (!ld_sel && ld_addr < COLS) mh[ld_addr] = ld_data[HW-1:0];
            if (ld_sel && ld_addr < ROWS)  mv[ld_addr] = ld_data[VW-1:0];
         end
         if (start && !was_run) begin
            mrun = 1; mdone = 0; mt = 0;
         end else if (was_run && res_valid) begin
            mh[exp_m[mt]] = res_xh;
            mv[exp_n[mt]] = res_xv;
            if (mt == STEPS - 1) begin mrun = 0; mdone = 1; end
            else mt++;
         end
      end
   end

   // Per-cycle comparison, away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 R5 R7 op_valid", 64'(op_valid), 64'(mrun));
         check("R5 done", 64'(done), 64'(mdone));
         if (mrun) begin
            check("R2 op_n", 64'(op_n), 64'(exp_n[mt]));
            check("R2 op_m", 64'(op_m), 64'(exp_m[mt]));
            check("R3 R4 R9 op_xh", 64'(op_xh), 64'(mh[exp_m[mt]]));
            check("R3 R4 R6 op_xv", 64'(op_xv), 64'(mv[exp_n[mt]]));
         end
      end
   end

   task automatic load(input bit sel, input int addr, input logic [LDW-1:0] val, input bit st);
      @(negedge clk);
      ld_en = 1; ld_sel = sel; ld_addr = 2'(addr); ld_data = val; start = st;
   endtask

   task automatic idle();
      @(negedge clk);
      ld_en = 0; start = 0;
   endtask

   // Serve one frame; at step poke a load and a start are attempted, at step probe an operand is checked.
   task automatic run_frame(input int fr, input int poke, input int probe, input bit probe_v,
                            input logic [63:0] probe_val, input string tag);
      for (int s = 0; s < STEPS; s++) begin
         if (s == probe)
            check(tag, probe_v ? 64'(op_xv) : 64'(op_xh), probe_val);
         if (s == poke) begin
            ld_en = 1; ld_sel = 1; ld_addr = 2'd2; ld_data = LDW'(48'hDEAD_BEEF); start = 1;
            @(negedge clk);
            ld_en = 0; start = 0;
            check("R7 start ignored n", 64'(op_n), 64'(exp_n[s]));
            check("R7 start ignored m", 64'(op_m), 64'(exp_m[s]));
         end
         repeat ((s * 3 + fr) % 4) @(negedge clk);
         res_xh = mh[exp_m[s]] + HW'(s * 257 + fr * 4096 + 1);
         res_xv = mv[exp_n[s]] ^ VW'(s * 65537 + fr + 3);
         res_valid = 1;
         @(negedge clk);
         res_valid = 0;
      end
      check("R5 done after last step", 64'(done), 64'd1);
      check("R5 op_valid low after last step", 64'(op_valid), 64'd0);
   endtask

   initial begin
      logic [HW-1:0] keep_h0;
      repeat (3) @(negedge clk);
      check("R1 op_valid in reset", 64'(op_valid), 64'd0);
      rst_n = 1;
      @(negedge clk);
      check("R1 op_valid after reset", 64'(op_valid), 64'd0);
      check("R1 done after reset", 64'(done), 64'd0);

      // Frame 0: boundary loads, the last one together with start.
      for (int m = 1; m < COLS; m++) load(0, m, LDW'(16'h0100 + m), 0);
      for (int n = 0; n < ROWS; n++) load(1, n, LDW'(16'h0200 + n), 0);
      load(0, 0, LDW'(16'h01AA), 1);
      idle();
      run_frame(0, -1, 0, 0, 64'h01AA, "R8 load with start");

      // Frame 1: reload vertical slots only; attempt a load and a start mid-run.
      repeat (3) @(negedge clk);
      check("R5 done holds while idle", 64'(done), 64'd1);
      for (int n = 0; n < ROWS; n++) load(1, n, LDW'(16'h0300 + n), 0);
      idle();
      start = 1;
      @(negedge clk);
      start = 0;
      check("R7 start clears done", 64'(done), 64'd0);
      run_frame(1, 2, 5, 1, 64'h0302, "R6 load during run ignored");

      // Frame 2: no reload at all; slots carry the previous frame's results.
      repeat (2) @(negedge clk);
      keep_h0 = mh[0];
      start = 1;
      @(negedge clk);
      start = 0;
      run_frame(2, -1, 0, 0, 64'(keep_h0), "R9 slot kept across frames");

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog expired act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule